// File: doc/BRIEF.md
# Serial ring barrier check-in node

One instance of this block sits beside each processor on a one-wire serial loop that carries barrier packets. Every packet on the loop names a barrier and holds how many processors still have to arrive at it. The processor checks in by loading the barrier number it is waiting for. The node then looks at each packet that passes. The first packet with a matching number after the check-in leaves the node with its count lowered by one. Later packets with that number pass through unchanged. When one of them shows a count of zero, the node releases its processor.

The loop output is a combinational function of the loop input and of registers that were set on earlier bit times, so the node adds only a gate or two to the loop delay. The processor side is a simple load strobe with a mode bit. In blocking mode a stall output is held from check-in until release. In non-blocking mode the processor carries on working and polls a sticky completion flag. The count field is two's complement. A check-in for the next round that meets the previous round's zero packet drives the count to minus one, so the early arrival is kept rather than lost.

Top module: `rbn_node`

## Requirements
- R1: After reset, stall_o, done_o and counted_o are 0 and ring_out equals ring_in.
- R2: A packet starts on the cycle frame_start is high. It is ID_W barrier bits, bit 0 first, followed by CNT_W count bits, least significant first, with the count in two's complement. ring_out carries the same bit position in the same cycle.
- R3: A node that is not checked in passes every bit through unchanged. So does a checked-in node for any packet whose barrier number differs in any bit, and for any bit outside a packet.
- R4: A checked-in node lowers the count of the first packet with a matching number by exactly one. The modified bits appear on ring_out in the same cycle as the matching ring_in bits.
- R5: Each check-in decrements only once. Later matching packets pass unchanged, and counted_o is 1 from the end of the decrementing packet until release.
- R6: A checked-in node releases when a matching packet leaves it with a count of zero. On the cycle after the last count bit, done_o is 1, stall_o is 0 and counted_o is 0.
- R7: A node whose own decrement produces a zero count releases at the end of that same packet.
- R8: If a checked-in node meets a matching packet with count 0, the packet leaves with count all ones (minus one), and the node does not release on it.
- R9: A load with ld_nonblock=0 raises stall_o on the next cycle until release. A load with ld_nonblock=1 never raises stall_o.
- R10: A load while the node is checked in (stall pending or counted) is ignored. The stored barrier number is unchanged.
- R11: A check-in accepted while a packet is in flight does not touch that packet. Only packets whose first bit arrives after the load are considered.
- R12: done_o stays 1 after release until the next accepted load, which clears it on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the loop |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in | input | 1 | Serial bit arriving from the upstream node |
| frame_start | input | 1 | High on bit 0 of a packet |
| ring_out | output | 1 | Serial bit sent to the downstream node |
| ld_valid | input | 1 | Check-in strobe from the processor |
| ld_id | input | ID_W | Barrier number to wait for |
| ld_nonblock | input | 1 | 1 selects non-blocking mode |
| stall_o | output | 1 | Processor hold in blocking mode |
| done_o | output | 1 | Sticky barrier-complete flag |
| counted_o | output | 1 | This node's decrement has been applied |

## Verification
The node sees packets for other barriers, packets whose number differs only in the top bit, repeated packets for its own barrier, and idle bits between packets. This separates the equality check, the once-only decrement and plain pass-through. Counts of 3, 1 and 0 arriving at a freshly checked-in node test three cases: an ordinary borrow, a decrement that itself reaches zero and releases at once, and a borrow that wraps to minus one without releasing. Loads issued while checked in and in the middle of a packet show whether the stored number is protected and whether a half-seen packet is left alone.

// File: rtl/rbn_pkg.sv
package rbn_pkg;
   typedef enum logic [1:0] {
      RBN_IDLE    = 2'd0,
      RBN_ARMED   = 2'd1,
      RBN_COUNTED = 2'd2
   } rbn_state_e;
endpackage

// File: rtl/rbn_bit_timer.sv
// Tracks the bit position inside a packet from the frame_start sideband.
module rbn_bit_timer #(
   parameter int ID_W  = 4,
   parameter int CNT_W = 4,
   localparam int PKT  = ID_W + CNT_W,
   localparam int PW   = $clog2(PKT + 1),
   localparam int IW   = (ID_W > 1) ? $clog2(ID_W) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   output logic          id_phase,
   output logic          cnt_phase,
   output logic          first_id,
   output logic          first_cnt,
   output logic          last_cnt,
   output logic [IW-1:0] id_sel
);
   localparam logic [PW-1:0] ID_END   = PW'(ID_W);
   localparam logic [PW-1:0] PKT_LAST = PW'(PKT - 1);

   logic [PW-1:0] pos_q;
   logic          busy_q;
   logic [PW-1:0] idx;
   logic          in_pkt;

   assign idx       = frame_start ? '0 : pos_q;
   assign in_pkt    = frame_start | busy_q;
   assign id_phase  = in_pkt & (idx < ID_END);
   assign cnt_phase = in_pkt & (idx >= ID_END);
   assign first_id  = frame_start;
   assign first_cnt = in_pkt & (idx == ID_END);
   assign last_cnt  = in_pkt & (idx == PKT_LAST);
   assign id_sel    = idx[IW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= '0;
         busy_q <= 1'b0;
      end else if (in_pkt) begin
         if (idx == PKT_LAST) begin
            pos_q  <= '0;
            busy_q <= 1'b0;
         end else begin
            pos_q  <= idx + 1'b1;
            busy_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rbn_id_compare.sv
// Bit-serial equality of the passing barrier number against the stored one.
module rbn_id_compare #(
   parameter int ID_W        = 4,
   parameter bit ID_MSB_FIRST = 1'b0,
   localparam int IW         = (ID_W > 1) ? $clog2(ID_W) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ring_in,
   input  logic            id_phase,
   input  logic            first_id,
   input  logic [IW-1:0]   id_sel,
   input  logic [ID_W-1:0] want_id,
   input  logic            eligible,
   output logic            match_q,
   output logic            elig_q
);
   logic ref_bit;
   logic eq_now;

   generate
      if (ID_MSB_FIRST) begin : g_msb
         logic [IW-1:0] rev;
         assign rev     = IW'(ID_W - 1) - id_sel;
         assign ref_bit = want_id[rev];
      end else begin : g_lsb
         assign ref_bit = want_id[id_sel];
      end
   endgenerate

   assign eq_now = ~(ring_in ^ ref_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         elig_q  <= 1'b0;
      end else begin
         if (first_id) begin
            match_q <= eq_now;
            elig_q  <= eligible;
         end else if (id_phase) begin
            match_q <= match_q & eq_now;
         end
      end
   end
endmodule

// File: rtl/rbn_serial_dec.sv
// In-flight serial subtract-one of the count field and zero detection.
module rbn_serial_dec (
   input  logic clk,
   input  logic rst_n,
   input  logic ring_in,
   input  logic cnt_phase,
   input  logic first_cnt,
   input  logic last_cnt,
   input  logic dec_en,
   output logic ring_out,
   output logic zero_end
);
   logic borrow_q;
   logic zero_q;
   logic borrow_in;
   logic zero_run;

   assign borrow_in = first_cnt ? 1'b1 : borrow_q;
   assign ring_out  = ring_in ^ (dec_en & borrow_in);
   assign zero_run  = (first_cnt ? 1'b1 : zero_q) & ~ring_out;
   assign zero_end  = last_cnt & zero_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         borrow_q <= 1'b0;
         zero_q   <= 1'b0;
      end else if (cnt_phase) begin
         borrow_q <= borrow_in & ~ring_in;
         zero_q   <= zero_run;
      end
   end
endmodule

// File: rtl/rbn_node.sv
module rbn_node #(
   parameter int ID_W         = 4,
   parameter int CNT_W        = 4,
   parameter bit ID_MSB_FIRST = 1'b0,
   localparam int IW          = (ID_W > 1) ? $clog2(ID_W) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ring_in,
   input  logic            frame_start,
   output logic            ring_out,
   input  logic            ld_valid,
   input  logic [ID_W-1:0] ld_id,
   input  logic            ld_nonblock,
   output logic            stall_o,
   output logic            done_o,
   output logic            counted_o
);
   import rbn_pkg::*;

   generate
      if (ID_W < 1) begin : g_bad_id
         $error("rbn_node: ID_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("rbn_node: CNT_W must be at least 2");
      end
   endgenerate

   rbn_state_e      state_q;
   logic [ID_W-1:0] want_id_q;
   logic            nonblock_q;
   logic            done_q;

   logic            id_phase, cnt_phase, first_id, first_cnt, last_cnt;
   logic [IW-1:0]   id_sel;
   logic            match_q, elig_q;
   logic            dec_en, zero_end;
   logic            accept, hit_end;

   rbn_bit_timer #(.ID_W(ID_W), .CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .id_phase   (id_phase),
      .cnt_phase  (cnt_phase),
      .first_id   (first_id),
      .first_cnt  (first_cnt),
      .last_cnt   (last_cnt),
      .id_sel     (id_sel)
   );

   rbn_id_compare #(.ID_W(ID_W), .ID_MSB_FIRST(ID_MSB_FIRST)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .ring_in (ring_in),
      .id_phase(id_phase),
      .first_id(first_id),
      .id_sel  (id_sel),
      .want_id (want_id_q),
      .eligible(state_q != RBN_IDLE),
      .match_q (match_q),
      .elig_q  (elig_q)
   );

   assign dec_en = cnt_phase & match_q & elig_q & (state_q == RBN_ARMED);

   rbn_serial_dec u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .ring_in  (ring_in),
      .cnt_phase(cnt_phase),
      .first_cnt(first_cnt),
      .last_cnt (last_cnt),
      .dec_en   (dec_en),
      .ring_out (ring_out),
      .zero_end (zero_end)
   );

   assign accept  = ld_valid & (state_q == RBN_IDLE);
   assign hit_end = last_cnt & match_q & elig_q & (state_q != RBN_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= RBN_IDLE;
         want_id_q  <= '0;
         nonblock_q <= 1'b0;
         done_q     <= 1'b0;
      end else if (accept) begin
         state_q    <= RBN_ARMED;
         want_id_q  <= ld_id;
         nonblock_q <= ld_nonblock;
         done_q     <= 1'b0;
      end else if (hit_end) begin
         if (zero_end) begin
            state_q <= RBN_IDLE;
            done_q  <= 1'b1;
         end else if (state_q == RBN_ARMED) begin
            state_q <= RBN_COUNTED;
         end
      end
   end

   assign stall_o   = (state_q != RBN_IDLE) & ~nonblock_q;
   assign done_o    = done_q;
   assign counted_o = (state_q == RBN_COUNTED);
endmodule

// File: rtl/rbn_node_chk.sv
module rbn_node_chk (
   input logic              clk,
   input logic              rst_n,
   input logic              ring_in,
   input logic              ring_out,
   input logic              ld_valid,
   input logic              stall_o,
   input logic              done_o,
   input logic              counted_o,
   input logic              nonblock_q,
   input rbn_pkg::rbn_state_e state_q
);
   import rbn_pkg::*;

   // R3
   pass_when_not_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_out != ring_in) |-> (state_q == RBN_ARMED));

   // R6
   stall_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> !done_o);

   // R9
   nonblock_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nonblock_q |-> !stall_o);

   // R10
   load_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && state_q == RBN_IDLE) |=> (state_q == RBN_ARMED && !done_o));

   // R5
   counted_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(counted_o) |-> ($past(state_q) == RBN_ARMED));

   // R12
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ld_valid) |=> done_o);
endmodule

bind rbn_node rbn_node_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ring_in   (ring_in),
   .ring_out  (ring_out),
   .ld_valid  (ld_valid),
   .stall_o   (stall_o),
   .done_o    (done_o),
   .counted_o (counted_o),
   .nonblock_q(nonblock_q),
   .state_q   (state_q)
);

// File: tb/rbn_node_test.sv
`timescale 1ns/1ps
module rbn_node_test;
   localparam int ID_W  = 4;
   localparam int CNT_W = 4;
   localparam int PKT   = ID_W + CNT_W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ring_in = 1'b0;
   logic            frame_start = 1'b0;
   logic            ring_out;
   logic            ld_valid = 1'b0;
   logic [ID_W-1:0] ld_id = '0;
   logic            ld_nonblock = 1'b0;
   logic            stall_o, done_o, counted_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [PKT-1:0] exp_q[$];
   string          tag_q[$];

   always #4 clk = ~clk;

   rbn_node #(.ID_W(ID_W), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .ring_in(ring_in), .frame_start(frame_start),
      .ring_out(ring_out), .ld_valid(ld_valid), .ld_id(ld_id),
      .ld_nonblock(ld_nonblock), .stall_o(stall_o), .done_o(done_o),
      .counted_o(counted_o)
   );

   task automatic check1(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   // Monitor: collects each packet leaving the node and compares with the scoreboard.
   initial begin
      logic [PKT-1:0] got;
      int             n;
      n = -1;
      got = '0;
      forever begin
         @(negedge clk);
         #2;
         if (rst_n) begin
            if (frame_start) n = 0;
            if (n >= 0) begin
               got[n] = ring_out;
               n++;
               if (n == PKT) begin
                  logic [PKT-1:0] e;
                  string          t;
                  checks++;
                  if (exp_q.size() == 0) begin
                     errors++;
                     $display("FAIL R2: packet %h with no expected entry", got);
                  end else begin
                     e = exp_q.pop_front();
                     t = tag_q.pop_front();
                     if (got !== e) begin
                        errors++;
                        $display("FAIL %s: got cnt=%0d id=%0d expected cnt=%0d id=%0d",
                                 t, got[PKT-1:ID_W], got[ID_W-1:0],
                                 e[PKT-1:ID_W], e[ID_W-1:0]);
                     end
                  end
                  n = -1;
               end
            end else begin
               check1("R3 gap pass-through", ring_out, ring_in);
            end
         end
      end
   end

   // Driver: pushes the expected packet, then sends it; optional load on bit ld_at.
   task automatic send_pkt(input logic [ID_W-1:0] id, input logic [CNT_W-1:0] cnt,
                           input logic [CNT_W-1:0] exp_cnt, input string tag,
                           input int ld_at = -1, input logic [ID_W-1:0] ld_val = '0);
      logic [PKT-1:0] w;
      w = {cnt, id};
      exp_q.push_back({exp_cnt, id});
      tag_q.push_back(tag);
      for (int i = 0; i < PKT; i++) begin
         @(negedge clk);
         frame_start = (i == 0);
         ring_in     = w[i];
         ld_valid    = (i == ld_at);
         ld_id       = ld_val;
         ld_nonblock = 1'b0;
      end
      @(negedge clk);
      frame_start = 1'b0;
      ring_in     = 1'b0;
      ld_valid    = 1'b0;
   endtask

   task automatic do_load(input logic [ID_W-1:0] id, input logic nb);
      @(negedge clk);
      ld_valid    = 1'b1;
      ld_id       = id;
      ld_nonblock = nb;
      @(negedge clk);
      ld_valid    = 1'b0;
   endtask

   task automatic idle_bits(input int n, input logic v);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ring_in = v ^ i[0];
      end
      @(negedge clk);
      ring_in = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check1("R1 stall", stall_o, 1'b0);
      check1("R1 done", done_o, 1'b0);
      check1("R1 counted", counted_o, 1'b0);
      ring_in = 1'b1; #1;
      check1("R1 pass-through", ring_out, 1'b1);
      ring_in = 1'b0;

      // R3 idle node leaves packets alone; R2 framing
      send_pkt(4'd5, 4'd3, 4'd3, "R3 idle node");

      // R9 blocking check-in
      do_load(4'd5, 1'b0);
      check1("R9 stall after blocking load", stall_o, 1'b1);
      check1("R9 done low", done_o, 1'b0);

      // R3 mismatches, including top bit only
      send_pkt(4'd6, 4'd3, 4'd3, "R3 other id");
      send_pkt(4'd13, 4'd3, 4'd3, "R3 msb differs");

      // R4 first match decrements
      send_pkt(4'd5, 4'd3, 4'd2, "R4 decrement");
      check1("R5 counted after decrement", counted_o, 1'b1);
      check1("R9 still stalled", stall_o, 1'b1);

      // R5 only once
      send_pkt(4'd5, 4'd2, 4'd2, "R5 second pass unchanged");
      check1("R5 no release on nonzero", done_o, 1'b0);

      idle_bits(5, 1'b1);

      // R6 release on zero
      send_pkt(4'd5, 4'd0, 4'd0, "R6 zero passes");
      check1("R6 done", done_o, 1'b1);
      check1("R6 stall low", stall_o, 1'b0);
      check1("R6 counted low", counted_o, 1'b0);

      // R12 sticky done, cleared by load; R9 nonblocking
      idle_bits(4, 1'b0);
      check1("R12 done sticky", done_o, 1'b1);
      do_load(4'd9, 1'b1);
      check1("R12 done cleared", done_o, 1'b0);
      check1("R9 no stall in nonblocking", stall_o, 1'b0);

      // R7 last arrival releases immediately
      send_pkt(4'd9, 4'd1, 4'd0, "R7 decrement to zero");
      check1("R7 released same packet", done_o, 1'b1);

      // R10 load ignored while checked in
      do_load(4'd3, 1'b0);
      do_load(4'd7, 1'b0);
      send_pkt(4'd7, 4'd4, 4'd4, "R10 ignored id not used");
      // R8 early check-in wraps to minus one
      send_pkt(4'd3, 4'd0, 4'd15, "R8 wrap to -1");
      check1("R8 no release", done_o, 1'b0);
      check1("R8 counted", counted_o, 1'b1);
      send_pkt(4'd3, 4'd2, 4'd2, "R5 counted node passes");
      send_pkt(4'd3, 4'd0, 4'd0, "R6 zero after wrap");
      check1("R6 release after wrap", done_o, 1'b1);

      // R11 load during a packet in flight
      send_pkt(4'd5, 4'd6, 4'd6, "R11 in-flight untouched", 2, 4'd5);
      check1("R11 load accepted", stall_o, 1'b1);
      send_pkt(4'd5, 4'd6, 4'd5, "R11 next packet decremented");
      send_pkt(4'd5, 4'd0, 4'd0, "R6 final zero");
      check1("R6 final release", done_o, 1'b1);

      repeat (3) @(negedge clk);
      check1("R2 all packets seen", exp_q.size() == 0, 1'b1);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule